// File: doc/BRIEF.md
# Bit-Error Statistics Counters with Coherent Snapshot

This block gathers bit-error-rate statistics on a received data stream. On every clock where the valid strobe is high, it XORs the received word with the expected word. It keeps two running totals. The first counts words that contain one or more mismatching bits. The second sums the number of mismatching bits. Generating the expected pattern and bridging to a system bus are left to neighbouring logic.

Software reads the totals through a small read port made of an address, a read strobe and registered read data. Every counter read is destructive: the value is returned and the counter restarts. Reading the word-error total also moves the live bit-error total into a shadow register in that same cycle. Software reads the word total first and the shadow second, so it always gets a matched pair however far apart the two accesses are.

Top module: `ber_cor_stats`

## Requirements
- R1: With valid high, the word-error counter grows by one when received and expected words differ in any bit; it does not change on a valid match or when valid is low.
- R2: With valid high, the bit-error counter grows by the number of set bits in the XOR of received and expected words.
- R3: A strobed read at offset 0 returns the word-error count on rd_data in the following cycle and clears that counter.
- R4: A strobed read at offset 0 copies the live bit-error count into the shadow register in that same cycle and clears the live bit-error counter.
- R5: A strobed read at offset 1 returns the shadow value without side effects; the shadow keeps its value until the next offset-0 read, whatever errors or other reads happen in between.
- R6: A strobed read at offset 2 returns the live bit-error count and clears it, leaving the shadow and the word-error counter untouched.
- R7: When an error word arrives in the same cycle as a clearing read, the cleared counter loads that cycle's increment instead of zero.
- R8: A strobed read at offset 3 returns zero and changes no state; rd_data is zero in any cycle that follows a cycle without a read strobe.
- R9: Both counters stop at their all-ones value instead of wrapping.
- R10: Synchronous reset clears both counters, the shadow register and rd_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Marks a word pair for comparison |
| rx_word | input | DATA_W | Received data word |
| ref_word | input | DATA_W | Expected data word |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Register offset (0 word errors, 1 shadow bits, 2 live bits) |
| rd_data | output | RD_W | Registered read data, valid the cycle after rd_en |

## Verification
The assertions assume that rd_addr is known whenever rd_en is high, that inputs settle away from the rising edge, and that reset is held for at least one edge before any traffic, so that all checks start from known state. The bench meets these conditions. It changes every input on the falling edge, asserts reset at time zero, and strobes only one read per access. The bench also shrinks the counter widths so that saturation happens within a few hundred cycles.

// File: rtl/ber_pkg.sv
package ber_pkg;

   // Register offsets; offset 0 must stay the snapshot trigger.
   localparam int unsigned OFF_WORD   = 0;
   localparam int unsigned OFF_SHADOW = 1;
   localparam int unsigned OFF_BITS   = 2;

   // Count-width helper for a population count of n bits.
   function automatic int unsigned pop_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ber_err_detect.sv
module ber_err_detect #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned POP_W        = 6,
   parameter bit          NIBBLE_SPLIT = 1'b1
) (
   input  logic              valid,
   input  logic [DATA_W-1:0] rx_word,
   input  logic [DATA_W-1:0] ref_word,
   output logic              word_inc,
   output logic [POP_W-1:0]  bit_inc
);

   logic [DATA_W-1:0] diff;
   logic [POP_W-1:0]  ones;

   assign diff = rx_word ^ ref_word;

   generate
      if (NIBBLE_SPLIT) begin : g_nibble
         localparam int unsigned NIB = DATA_W / 4;
         logic [2:0] nib_cnt [NIB];

         for (genvar g = 0; g < NIB; g++) begin : g_nib
            assign nib_cnt[g] = {2'b00, diff[4*g]}   + {2'b00, diff[4*g+1]}
                              + {2'b00, diff[4*g+2]} + {2'b00, diff[4*g+3]};
         end

         always_comb begin
            ones = '0;
            for (int i = 0; i < NIB; i++) begin
               ones = ones + POP_W'(nib_cnt[i]);
            end
         end
      end else begin : g_linear
         always_comb begin
            ones = '0;
            for (int i = 0; i < DATA_W; i++) begin
               ones = ones + POP_W'(diff[i]);
            end
         end
      end
   endgenerate

   assign word_inc = valid && (diff != '0);
   assign bit_inc  = valid ? ones : '0;

endmodule

// File: rtl/ber_sat_counter.sv
module ber_sat_counter #(
   parameter int unsigned W     = 16,
   parameter int unsigned INC_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     count
);

   localparam logic [W-1:0] TOP = '1;

   logic [W:0]   wide_sum;
   logic [W-1:0] sat_sum;
   logic [W-1:0] count_q;

   assign wide_sum = {1'b0, count_q} + (W+1)'(inc);
   assign sat_sum  = wide_sum[W] ? TOP : wide_sum[W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (clr) begin
         // Clear wins over accumulate, but this cycle's increment is kept.
         count_q <= W'(inc);
      end else begin
         count_q <= sat_sum;
      end
   end

   assign count = count_q;

endmodule

// File: rtl/ber_read_port.sv
module ber_read_port
   import ber_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned WCNT_W = 16,
   parameter int unsigned BCNT_W = 24,
   parameter int unsigned RD_W   = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [WCNT_W-1:0] word_cnt,
   input  logic [BCNT_W-1:0] bit_cnt,
   output logic              clr_word,
   output logic              clr_bits,
   output logic [BCNT_W-1:0] shadow,
   output logic [RD_W-1:0]   rd_data
);

   logic              hit_word;
   logic              hit_shadow;
   logic              hit_bits;
   logic [RD_W-1:0]   mux_data;
   logic [BCNT_W-1:0] shadow_q;
   logic [RD_W-1:0]   data_q;

   assign hit_word   = rd_en && (rd_addr == ADDR_W'(OFF_WORD));
   assign hit_shadow = rd_en && (rd_addr == ADDR_W'(OFF_SHADOW));
   assign hit_bits   = rd_en && (rd_addr == ADDR_W'(OFF_BITS));

   assign clr_word = hit_word;
   assign clr_bits = hit_word || hit_bits;

   always_comb begin
      mux_data = '0;
      if (hit_word)   mux_data = RD_W'(word_cnt);
      if (hit_shadow) mux_data = RD_W'(shadow_q);
      if (hit_bits)   mux_data = RD_W'(bit_cnt);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
         data_q   <= '0;
      end else begin
         data_q <= mux_data;
         if (hit_word) begin
            shadow_q <= bit_cnt;
         end
      end
   end

   assign shadow  = shadow_q;
   assign rd_data = data_q;

endmodule

// File: rtl/ber_cor_stats.sv
module ber_cor_stats
   import ber_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned WCNT_W       = 16,
   parameter int unsigned BCNT_W       = 24,
   parameter int unsigned ADDR_W       = 2,
   parameter bit          NIBBLE_SPLIT = 1'b1,
   localparam int unsigned RD_W        = max_u(WCNT_W, BCNT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic [DATA_W-1:0] rx_word,
   input  logic [DATA_W-1:0] ref_word,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data
);

   localparam int unsigned POP_W = pop_width(DATA_W);

   generate
      if (BCNT_W < POP_W) begin : g_chk_bcnt
         $error("BCNT_W must hold one word's worth of bit errors");
      end
      if (WCNT_W < 1) begin : g_chk_wcnt
         $error("WCNT_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_chk_addr
         $error("ADDR_W must reach offset 2");
      end
      if (NIBBLE_SPLIT && (DATA_W % 4 != 0)) begin : g_chk_nib
         $error("nibble split needs DATA_W divisible by 4");
      end
   endgenerate

   logic              word_inc;
   logic [POP_W-1:0]  bit_inc;
   logic              clr_word;
   logic              clr_bits;
   logic [WCNT_W-1:0] word_cnt;
   logic [BCNT_W-1:0] bit_cnt;
   logic [BCNT_W-1:0] shadow_q;

   ber_err_detect #(
      .DATA_W      (DATA_W),
      .POP_W       (POP_W),
      .NIBBLE_SPLIT(NIBBLE_SPLIT)
   ) u_detect (
      .valid   (valid),
      .rx_word (rx_word),
      .ref_word(ref_word),
      .word_inc(word_inc),
      .bit_inc (bit_inc)
   );

   ber_sat_counter #(
      .W    (WCNT_W),
      .INC_W(1)
   ) u_word_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr_word),
      .inc  (word_inc),
      .count(word_cnt)
   );

   ber_sat_counter #(
      .W    (BCNT_W),
      .INC_W(POP_W)
   ) u_bit_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr_bits),
      .inc  (bit_inc),
      .count(bit_cnt)
   );

   ber_read_port #(
      .ADDR_W(ADDR_W),
      .WCNT_W(WCNT_W),
      .BCNT_W(BCNT_W),
      .RD_W  (RD_W)
   ) u_rport (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .word_cnt(word_cnt),
      .bit_cnt (bit_cnt),
      .clr_word(clr_word),
      .clr_bits(clr_bits),
      .shadow  (shadow_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/ber_cor_stats_chk.sv
module ber_cor_stats_chk #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned WCNT_W = 16,
   parameter int unsigned BCNT_W = 24,
   parameter int unsigned POP_W  = 6,
   parameter int unsigned RD_W   = 24
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [RD_W-1:0]   rd_data,
   input logic              word_inc,
   input logic [POP_W-1:0]  bit_inc,
   input logic [WCNT_W-1:0] word_cnt,
   input logic [BCNT_W-1:0] bit_cnt,
   input logic [BCNT_W-1:0] shadow
);

   localparam logic [WCNT_W-1:0] WTOP = '1;

   logic rd0;
   logic rd2;
   logic rd3;
   assign rd0 = rd_en && (rd_addr == ADDR_W'(0));
   assign rd2 = rd_en && (rd_addr == ADDR_W'(2));
   assign rd3 = rd_en && (rd_addr == ADDR_W'(3));

   // R3: word read returns previous count
   a_r3_word_read: assert property (@(posedge clk) disable iff (rst)
      rd0 |=> rd_data == RD_W'($past(word_cnt)));

   // R4: snapshot captures live bit count
   a_r4_snapshot: assert property (@(posedge clk) disable iff (rst)
      rd0 |=> shadow == $past(bit_cnt));

   // R5: shadow holds between word reads
   a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
      !rd0 |=> $stable(shadow));

   // R7: clear with simultaneous error keeps the increment
   a_r7_word_no_loss: assert property (@(posedge clk) disable iff (rst)
      rd0 |=> word_cnt == WCNT_W'($past(word_inc)));

   a_r7_bits_no_loss: assert property (@(posedge clk) disable iff (rst)
      (rd0 || rd2) |=> bit_cnt == BCNT_W'($past(bit_inc)));

   // R8: unmapped offset reads zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      rd3 |=> rd_data == '0);

   a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> rd_data == '0);

   // R9: word counter never wraps
   a_r9_word_sat: assert property (@(posedge clk) disable iff (rst)
      (word_cnt == WTOP && !rd0) |=> word_cnt == WTOP);

   a_r9_bits_monotonic: assert property (@(posedge clk) disable iff (rst)
      !(rd0 || rd2) |=> bit_cnt >= $past(bit_cnt));

endmodule

bind ber_cor_stats ber_cor_stats_chk #(
   .ADDR_W(ADDR_W),
   .WCNT_W(WCNT_W),
   .BCNT_W(BCNT_W),
   .POP_W (POP_W),
   .RD_W  (RD_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .word_inc(word_inc),
   .bit_inc (bit_inc),
   .word_cnt(word_cnt),
   .bit_cnt (bit_cnt),
   .shadow  (shadow_q)
);

// File: tb/sim_ber_cor_stats.sv
module sim_ber_cor_stats;

   localparam int DATA_W = 32;
   localparam int WCNT_W = 8;
   localparam int BCNT_W = 10;
   localparam int ADDR_W = 2;
   localparam int RD_W   = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              valid = 1'b0;
   logic [DATA_W-1:0] rx_word = '0;
   logic [DATA_W-1:0] ref_word = '0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [RD_W-1:0]   rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   ber_cor_stats #(
      .DATA_W(DATA_W),
      .WCNT_W(WCNT_W),
      .BCNT_W(BCNT_W),
      .ADDR_W(ADDR_W)
   ) u0 (
      .clk     (clk),
      .rst     (rst),
      .valid   (valid),
      .rx_word (rx_word),
      .ref_word(ref_word),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // Vector table: valid, received, expected, number of mismatching bits.
   localparam int NV = 8;
   localparam logic              TV_VAL  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam logic [DATA_W-1:0] TV_RX   [NV] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_FFFF,
                                                  32'hA5A5_A5A5, 32'hF0F0_F0F0, 32'h8000_0001, 32'h1234_5678};
   localparam logic [DATA_W-1:0] TV_REF  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                                  32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h0, 32'h1234_5670};
   localparam int                TV_BITS [NV] = '{0, 1, 32, 0, 0, 32, 2, 1};

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_read(input int addr, output int val);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = ADDR_W'(addr);
      @(negedge clk);
      rd_en   = 1'b0;
      val     = int'(rd_data);
   endtask

   task automatic push(input logic [DATA_W-1:0] rx, input logic [DATA_W-1:0] rf, input int cycles);
      @(negedge clk);
      valid    = 1'b1;
      rx_word  = rx;
      ref_word = rf;
      repeat (cycles - 1) @(negedge clk);
      @(negedge clk);
      valid = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      chk("R10 rd_data in reset", int'(rd_data), 0);
      rst = 1'b0;
      do_read(0, v); chk("R10 word after reset", v, 0);
      do_read(1, v); chk("R10 shadow after reset", v, 0);
      do_read(2, v); chk("R10 bits after reset", v, 0);

      // Table walk: one vector, then word read (snapshot) and shadow read.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         valid    = TV_VAL[i];
         rx_word  = TV_RX[i];
         ref_word = TV_REF[i];
         @(negedge clk);
         valid = 1'b0;
         do_read(0, v);
         chk("R1 R3 word count per vector", v, (TV_VAL[i] && TV_BITS[i] != 0) ? 1 : 0);
         do_read(1, v);
         chk("R2 R4 R5 shadow bits per vector", v, TV_VAL[i] ? TV_BITS[i] : 0);
      end

      // R5/R6: shadow (=1) holds across errors and live-bit reads.
      push(32'h7, 32'h0, 40);              // 40 words, 3 bits each = 120
      do_read(2, v); chk("R6 live bit read", v, 120);
      do_read(2, v); chk("R6 live bit cleared", v, 0);
      do_read(1, v); chk("R5 shadow held", v, 1);
      do_read(1, v); chk("R5 shadow re-read no side effect", v, 1);
      do_read(0, v); chk("R6 word count untouched by bit read", v, 40);
      do_read(1, v); chk("R4 snapshot after bit clear", v, 0);

      // R7: error arrives in the cycle of the word read.
      push(32'h1, 32'h0, 2);               // words 2, bits 2
      @(negedge clk);
      valid = 1'b1; rx_word = 32'h1F; ref_word = 32'h0;  // 5 bits
      rd_en = 1'b1; rd_addr = 2'd0;
      @(negedge clk);
      valid = 1'b0; rd_en = 1'b0;
      chk("R7 read returns old word count", int'(rd_data), 2);
      do_read(1, v); chk("R7 shadow got old bits", v, 2);
      do_read(2, v); chk("R7 bits kept same-cycle increment", v, 5);
      do_read(0, v); chk("R7 word kept same-cycle increment", v, 1);

      // R8: unmapped offset and idle rd_data.
      push(32'h3, 32'h0, 1);
      do_read(3, v); chk("R8 unmapped reads zero", v, 0);
      @(negedge clk);
      chk("R8 idle rd_data zero", int'(rd_data), 0);
      do_read(2, v); chk("R8 bits survive unmapped read", v, 2);
      do_read(0, v); chk("R8 word survives unmapped read", v, 1);

      // R9: saturation of both counters.
      push(32'hFFFF_FFFF, 32'h0, 300);
      do_read(2, v); chk("R9 bit counter saturates", v, 1023);
      do_read(0, v); chk("R9 word counter saturates", v, 255);

      // R10: reset mid-run clears everything.
      push(32'hF, 32'h0, 3);
      do_read(0, v);
      push(32'hF, 32'h0, 3);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R10 rd_data after reset", int'(rd_data), 0);
      do_read(1, v); chk("R10 shadow cleared", v, 0);
      do_read(2, v); chk("R10 bits cleared", v, 0);
      do_read(0, v); chk("R10 word cleared", v, 0);

      finish_up();
   end

endmodule